// File: doc/BRIEF.md
# CCD Pixel Region and Bayer Tagger

This block sits right after the analog front end's converter and before any colour processing. It takes a stream of digitized samples from an interline CCD. A line-start flag and a frame-start flag come with the samples. The block works out where each sample lies in the sensor's readout raster. Each sample is tagged as a horizontal or vertical dummy position, an optical-black (shielded) pixel, an effective image pixel, or an out-of-raster sample to be ignored. Effective pixels also receive their colour-filter phase.

The black reference is measured on every line that carries real pixels. It is the mean of a power-of-two run of samples taken at the start of the rear shielded window of that line. The next line subtracts this level from its effective pixels, and the result is held at zero so it never goes negative. The first image line therefore uses the level measured on the last shielded line above the image area. Downstream logic receives clamped effective pixels with a valid strobe, the colour code, a frame-start marker and a line-end marker. All outputs appear one clock after the sample.

Top module: `ccd_bayer_tagger`

## Requirements
- R1: While reset is high, and on the first clock after it, out_tag_valid, out_valid, out_sof, out_eol, out_data, out_region and out_color are all zero.
- R2: Within a line, counting from the sample marked by in_hd as column 0, the columns are laid out in this order: H_DUMMY dummy columns (region code 0), H_FOB shielded columns (code 1), H_EFF effective columns (code 2), then H_ROB shielded columns (code 1).
- R3: Counting from the line whose first sample carries in_vd as row 0, the rows are laid out in this order: V_DUMMY dummy rows, V_FOB shielded rows, V_EFF effective rows, then V_ROB shielded rows. A sample in a dummy row has code 0 unless its column is out of range. A sample in a shielded row has code 1 unless its column is dummy or out of range.
- R4: Samples with a column at or beyond the line total, or a row at or beyond the frame total, get region code 3 and never raise out_valid. This also covers every sample that arrives before the first in_vd.
- R5: The colour code of an effective pixel is 2*(effective row parity) + (effective column parity), with both counted from 0 at the first effective row and column. This gives 0 = red, 1 = green on a red line, 2 = green on a blue line, 3 = blue. The first effective row is a red/green line.
- R6: The black level is the floor of the mean of the first 2^OB_LOG2 rear shielded samples of the most recent non-dummy, in-range row. Each effective pixel is output as its sample minus that level.
- R7: When the sample is below the black level, out_data is 0 rather than a wrapped value.
- R8: The first effective row uses the black level measured on the last front shielded row.
- R9: out_sof is high only with the first effective pixel of the first effective row.
- R10: out_eol is high only with the last effective pixel of each effective row.
- R11: Each output reflects the sample taken one clock earlier. out_tag_valid equals the previous cycle's in_valid. out_data, out_color, out_sof and out_eol are zero when out_valid is low.
- R12: in_vd has no effect unless in_hd is high in the same valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_hd | input | 1 | Sample is the first of a line |
| in_vd | input | 1 | With in_hd: line is the first of a frame |
| in_data | input | DW | Digitized sample |
| out_tag_valid | output | 1 | A tagged sample is present |
| out_region | output | 2 | 0 dummy, 1 shielded, 2 effective, 3 ignored |
| out_valid | output | 1 | Clamped effective pixel present |
| out_data | output | DW | Black-corrected pixel value |
| out_color | output | 2 | Colour phase of the pixel |
| out_sof | output | 1 | First pixel of the frame image |
| out_eol | output | 1 | Last pixel of an image line |

## Verification
A column counter that is off by one moves every region boundary, and the colour parity flips with it. Such a fault shows on the very next line as a wrong region code or colour at a window edge, and out_eol appears a pixel early or late. A fault in the black accumulator or its latch shows as a constant offset on every pixel of the following line. The pixels whose sample lies near the black level show it first, because they switch between zero and a small value. Row-counter faults show as shielded rows tagged effective, or as out_sof appearing on the wrong line, within the same frame.

// File: rtl/ccd_tag_pkg.sv
package ccd_tag_pkg;

    typedef enum logic [1:0] {
        RG_DUMMY = 2'd0,
        RG_OB    = 2'd1,
        RG_EFF   = 2'd2,
        RG_IGN   = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        CF_R  = 2'd0,
        CF_GR = 2'd1,
        CF_GB = 2'd2,
        CF_B  = 2'd3
    } cfa_e;

    typedef struct packed {
        region_e region;
        cfa_e    cfa;
        logic    first_line;
        logic    first_col;
        logic    last_col;
        logic    ob_win;
        logic    ob_first;
        logic    ob_last;
    } pos_tag_t;

    function automatic cfa_e cfa_of(input logic line_odd, input logic col_odd);
        return cfa_e'({line_odd, col_odd});
    endfunction

    function automatic region_e region_of(input logic out_rng, input logic dummy,
                                          input logic shield);
        if (out_rng)     return RG_IGN;
        else if (dummy)  return RG_DUMMY;
        else if (shield) return RG_OB;
        else             return RG_EFF;
    endfunction

endpackage

// File: rtl/ccd_pos_tracker.sv
module ccd_pos_tracker
    import ccd_tag_pkg::*;
#(
    parameter int H_DUMMY = 16,
    parameter int H_FOB   = 2,
    parameter int H_EFF   = 659,
    parameter int H_ROB   = 31,
    parameter int V_DUMMY = 5,
    parameter int V_FOB   = 8,
    parameter int V_EFF   = 494,
    parameter int V_ROB   = 2,
    parameter int OB_LOG2 = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  logic     in_hd,
    input  logic     in_vd,
    output pos_tag_t tag
);
    localparam int H_TOTAL = H_DUMMY + H_FOB + H_EFF + H_ROB;
    localparam int V_TOTAL = V_DUMMY + V_FOB + V_EFF + V_ROB;
    localparam int COL_W   = $clog2(H_TOTAL + 1);
    localparam int ROW_W   = $clog2(V_TOTAL + 1);
    localparam int OB_N    = 1 << OB_LOG2;

    localparam logic [COL_W-1:0] C_FOB0 = COL_W'(H_DUMMY);
    localparam logic [COL_W-1:0] C_EFF0 = COL_W'(H_DUMMY + H_FOB);
    localparam logic [COL_W-1:0] C_ROB0 = COL_W'(H_DUMMY + H_FOB + H_EFF);
    localparam logic [COL_W-1:0] C_WEND = COL_W'(H_DUMMY + H_FOB + H_EFF + OB_N);
    localparam logic [COL_W-1:0] C_SAT  = COL_W'(H_TOTAL);
    localparam logic [ROW_W-1:0] R_FOB0 = ROW_W'(V_DUMMY);
    localparam logic [ROW_W-1:0] R_EFF0 = ROW_W'(V_DUMMY + V_FOB);
    localparam logic [ROW_W-1:0] R_ROB0 = ROW_W'(V_DUMMY + V_FOB + V_EFF);
    localparam logic [ROW_W-1:0] R_SAT  = ROW_W'(V_TOTAL);

    logic [COL_W-1:0] col_q, cur_col;
    logic [ROW_W-1:0] row_q, cur_row;

    // next position of the present sample; both counters stick at their limit
    always_comb begin
        if (in_hd)               cur_col = '0;
        else if (col_q == C_SAT) cur_col = col_q;
        else                     cur_col = col_q + 1'b1;

        if (!in_hd)              cur_row = row_q;
        else if (in_vd)          cur_row = '0;
        else if (row_q == R_SAT) cur_row = row_q;
        else                     cur_row = row_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= C_SAT;
            row_q <= R_SAT;
        end else if (in_valid) begin
            col_q <= cur_col;
            row_q <= cur_row;
        end
    end

    logic col_dummy, col_eff, col_out, col_ob;
    logic row_dummy, row_eff, row_out, row_ob;
    logic col_odd, row_odd, meas_row, in_win;
    region_e region;

    always_comb begin
        col_dummy = cur_col < C_FOB0;
        col_eff   = (cur_col >= C_EFF0) && (cur_col < C_ROB0);
        col_out   = cur_col >= C_SAT;
        col_ob    = !col_dummy && !col_eff && !col_out;

        row_dummy = cur_row < R_FOB0;
        row_eff   = (cur_row >= R_EFF0) && (cur_row < R_ROB0);
        row_out   = cur_row >= R_SAT;
        row_ob    = !row_dummy && !row_eff && !row_out;

        col_odd   = cur_col[0] ^ C_EFF0[0];
        row_odd   = cur_row[0] ^ R_EFF0[0];
        meas_row  = !row_dummy && !row_out;
        in_win    = (cur_col >= C_ROB0) && (cur_col < C_WEND);

        region    = region_of(col_out || row_out, col_dummy || row_dummy, col_ob || row_ob);

        tag.region     = region;
        tag.cfa        = (region == RG_EFF) ? cfa_of(row_odd, col_odd) : CF_R;
        tag.first_line = cur_row == R_EFF0;
        tag.first_col  = cur_col == C_EFF0;
        tag.last_col   = cur_col == (C_ROB0 - 1'b1);
        tag.ob_win     = meas_row && in_win;
        tag.ob_first   = cur_col == C_ROB0;
        tag.ob_last    = cur_col == (C_WEND - 1'b1);
    end

    // R4: a column past the line total is never tagged as anything but ignored
    a_r4_sat_col_ignored: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_hd && col_q == C_SAT) |-> (tag.region == RG_IGN));

    // R2: inside a line the column advances by exactly one per valid sample
    a_r2_col_steps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_hd && col_q != C_SAT) |=> (col_q == $past(col_q) + 1'b1));

    // R12: the row count never moves without a line start
    a_r12_row_holds: assert property (@(posedge clk) disable iff (rst)
        (!(in_valid && in_hd)) |=> $stable(row_q));

endmodule

// File: rtl/ccd_ob_clamp.sv
module ccd_ob_clamp #(
    parameter int DW      = 12,
    parameter int OB_LOG2 = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          ob_win,
    input  logic          ob_first,
    input  logic          ob_last,
    output logic [DW-1:0] black
);
    localparam int AW = DW + OB_LOG2;

    logic [AW-1:0] acc_q, sum;
    logic [DW-1:0] black_q;

    always_comb begin
        if (ob_first) sum = AW'(in_data);
        else          sum = acc_q + AW'(in_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            black_q <= '0;
        end else if (in_valid && ob_win) begin
            acc_q <= sum;
            if (ob_last) black_q <= DW'(sum >> OB_LOG2);
        end
    end

    assign black = black_q;

    // R6: the level is replaced only when the averaging window completes
    a_r6_black_only_at_window_end: assert property (@(posedge clk) disable iff (rst)
        (!(in_valid && ob_win && ob_last)) |=> $stable(black_q));

endmodule

// File: rtl/ccd_pix_out.sv
module ccd_pix_out
    import ccd_tag_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] black,
    input  region_e       region,
    input  cfa_e          cfa,
    input  logic          first_line,
    input  logic          first_col,
    input  logic          last_col,
    output logic          out_tag_valid,
    output logic [1:0]    out_region,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic [1:0]    out_color,
    output logic          out_sof,
    output logic          out_eol
);
    logic [DW:0]   diff;
    logic [DW-1:0] clamped;
    logic          eff;

    logic          tv_q, val_q, sof_q, eol_q;
    region_e       reg_q;
    cfa_e          cfa_q;
    logic [DW-1:0] data_q;

    always_comb begin
        diff    = {1'b0, in_data} - {1'b0, black};
        clamped = diff[DW] ? '0 : diff[DW-1:0];
        eff     = in_valid && (region == RG_EFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tv_q   <= 1'b0;
            reg_q  <= RG_DUMMY;
            val_q  <= 1'b0;
            data_q <= '0;
            cfa_q  <= CF_R;
            sof_q  <= 1'b0;
            eol_q  <= 1'b0;
        end else begin
            tv_q   <= in_valid;
            reg_q  <= in_valid ? region : RG_DUMMY;
            val_q  <= eff;
            data_q <= eff ? clamped : '0;
            cfa_q  <= eff ? cfa : CF_R;
            sof_q  <= eff && first_line && first_col;
            eol_q  <= eff && last_col;
        end
    end

    assign out_tag_valid = tv_q;
    assign out_region    = reg_q;
    assign out_valid     = val_q;
    assign out_data      = data_q;
    assign out_color     = cfa_q;
    assign out_sof       = sof_q;
    assign out_eol       = eol_q;

    // R7: subtracting a level can never raise a pixel above its raw sample
    a_r7_not_above_input: assert property (@(posedge clk) disable iff (rst)
        (in_valid && region == RG_EFF) |=> (out_data <= $past(in_data)));

    // R9: the frame marker lands on a red pixel that is being output
    a_r9_sof_is_red: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> (out_valid && out_color == 2'(CF_R)));

    // R10: a line-end marker only accompanies an output pixel
    a_r10_eol_with_pixel: assert property (@(posedge clk) disable iff (rst)
        out_eol |-> out_valid);

endmodule

// File: rtl/ccd_bayer_tagger.sv
module ccd_bayer_tagger
    import ccd_tag_pkg::*;
#(
    parameter int DW      = 12,
    parameter int H_DUMMY = 16,
    parameter int H_FOB   = 2,
    parameter int H_EFF   = 659,
    parameter int H_ROB   = 31,
    parameter int V_DUMMY = 5,
    parameter int V_FOB   = 8,
    parameter int V_EFF   = 494,
    parameter int V_ROB   = 2,
    parameter int OB_LOG2 = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_hd,
    input  logic          in_vd,
    input  logic [DW-1:0] in_data,
    output logic          out_tag_valid,
    output logic [1:0]    out_region,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic [1:0]    out_color,
    output logic          out_sof,
    output logic          out_eol
);
    pos_tag_t      tag;
    logic [DW-1:0] black;

    ccd_pos_tracker #(
        .H_DUMMY(H_DUMMY), .H_FOB(H_FOB), .H_EFF(H_EFF), .H_ROB(H_ROB),
        .V_DUMMY(V_DUMMY), .V_FOB(V_FOB), .V_EFF(V_EFF), .V_ROB(V_ROB),
        .OB_LOG2(OB_LOG2)
    ) u_pos (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_hd    (in_hd),
        .in_vd    (in_vd),
        .tag      (tag)
    );

    ccd_ob_clamp #(
        .DW(DW), .OB_LOG2(OB_LOG2)
    ) u_clamp (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .ob_win   (tag.ob_win),
        .ob_first (tag.ob_first),
        .ob_last  (tag.ob_last),
        .black    (black)
    );

    ccd_pix_out #(
        .DW(DW)
    ) u_out (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .black         (black),
        .region        (tag.region),
        .cfa           (tag.cfa),
        .first_line    (tag.first_line),
        .first_col     (tag.first_col),
        .last_col      (tag.last_col),
        .out_tag_valid (out_tag_valid),
        .out_region    (out_region),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_color     (out_color),
        .out_sof       (out_sof),
        .out_eol       (out_eol)
    );

    // R11: a tagged sample appears exactly one clock after each input sample
    a_r11_tag_follows_input: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_tag_valid);

    a_r11_no_tag_without_input: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_tag_valid);

endmodule

// File: tb/test_ccd_bayer_tagger.sv
`timescale 1ns/1ps
module test_ccd_bayer_tagger;
    localparam int DW = 10;
    localparam int HD = 2, HF = 1, HE = 7, HR = 5;
    localparam int VD = 1, VF = 2, VE = 4, VR = 1;
    localparam int L  = 2;
    localparam int HT = HD + HF + HE + HR;
    localparam int VT = VD + VF + VE + VR;
    localparam int ROB0 = HD + HF + HE;
    localparam int OBN = 1 << L;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_hd, in_vd;
    logic [DW-1:0] in_data;
    logic out_tag_valid, out_valid, out_sof, out_eol;
    logic [1:0] out_region, out_color;
    logic [DW-1:0] out_data;

    always #2.5 clk = ~clk;

    ccd_bayer_tagger #(
        .DW(DW), .H_DUMMY(HD), .H_FOB(HF), .H_EFF(HE), .H_ROB(HR),
        .V_DUMMY(VD), .V_FOB(VF), .V_EFF(VE), .V_ROB(VR), .OB_LOG2(L)
    ) i_ccd_bayer_tagger (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_hd(in_hd), .in_vd(in_vd),
        .in_data(in_data), .out_tag_valid(out_tag_valid), .out_region(out_region),
        .out_valid(out_valid), .out_data(out_data), .out_color(out_color),
        .out_sof(out_sof), .out_eol(out_eol)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference state
    int mcol = HT, mrow = VT, macc = 0, mblack = 0;
    bit has_exp = 0;
    bit stray_line = 0;
    int e_tv, e_reg, e_val, e_data, e_col, e_sof, e_eol;
    string e_rreq, e_dreq;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_prev();
        if (!has_exp) return;
        chk(out_tag_valid == e_tv[0], "R11", "tag_valid", out_tag_valid, e_tv);
        if (e_tv != 0) chk(out_region == e_reg, e_rreq, "region", out_region, e_reg);
        chk(out_valid == e_val[0], e_rreq, "valid", out_valid, e_val);
        chk(out_data == e_data, e_val != 0 ? e_dreq : "R11", "data", out_data, e_data);
        chk(out_color == e_col, "R5", "color", out_color, e_col);
        chk(out_sof == e_sof[0], "R9", "sof", out_sof, e_sof);
        chk(out_eol == e_eol[0], "R10", "eol", out_eol, e_eol);
    endtask

    task automatic predict(input bit hd, input bit vd, input bit v, input int d);
        bit cdum, ceff, cout, rdum, reff, rout, cob, rob;
        int x, y, diff;
        has_exp = 1;
        e_tv = v; e_val = 0; e_data = 0; e_col = 0; e_sof = 0; e_eol = 0; e_reg = 0;
        e_rreq = "R11"; e_dreq = "R6";
        if (!v) return;
        if (hd) begin
            mcol = 0;
            stray_line = 0;
            if (vd) mrow = 0; else if (mrow < VT) mrow++;
        end else begin
            if (vd) stray_line = 1;
            if (mcol < HT) mcol++;
        end
        cdum = mcol < HD; ceff = mcol >= HD + HF && mcol < ROB0; cout = mcol >= HT;
        rdum = mrow < VD; reff = mrow >= VD + VF && mrow < VD + VF + VE; rout = mrow >= VT;
        cob = !cdum && !ceff && !cout; rob = !rdum && !reff && !rout;
        if (cout || rout) begin e_reg = 3; e_rreq = "R4"; end
        else if (cdum || rdum) begin e_reg = 0; e_rreq = rdum ? "R3" : "R2"; end
        else if (cob || rob) begin e_reg = 1; e_rreq = rob ? "R3" : "R2"; end
        else begin e_reg = 2; e_rreq = "R2"; end
        if (stray_line) e_rreq = "R12";
        if (e_reg == 2) begin
            x = mcol - (HD + HF); y = mrow - (VD + VF);
            diff = d - mblack;
            e_val = 1;
            e_data = diff < 0 ? 0 : diff;
            e_col = (y % 2) * 2 + (x % 2);
            e_sof = (x == 0 && y == 0);
            e_eol = (x == HE - 1);
            e_dreq = diff < 0 ? "R7" : (y == 0 ? "R8" : "R6");
        end
        if (!rdum && !rout && mcol >= ROB0 && mcol < ROB0 + OBN) begin
            macc = (mcol == ROB0) ? d : macc + d;
            if (mcol == ROB0 + OBN - 1) mblack = macc >> L;
        end
    endtask

    task automatic send(input bit hd, input bit vd, input bit v, input int d);
        @(negedge clk);
        check_prev();
        in_valid = v; in_hd = hd; in_vd = vd; in_data = DW'(d);
        predict(hd, vd, v, d);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; in_valid = 0; in_hd = 0; in_vd = 0; in_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({out_tag_valid, out_valid, out_sof, out_eol} == 4'b0 && out_data == 0
            && out_region == 0 && out_color == 0, "R1", "reset outputs",
            {out_tag_valid, out_valid, out_sof, out_eol}, 0);
        @(negedge clk);
        rst = 0;
        chk(out_tag_valid == 0 && out_valid == 0, "R1", "after reset", out_valid, 0);
        // R4: samples before any frame start are ignored
        send(1, 0, 1, 500);
        for (int i = 0; i < 4; i++) send(0, 0, 1, 300 + i);
        // frames with random content
        for (int f = 0; f < 8; f++) begin
            int ob_lvl, nl;
            ob_lvl = 64 + int'($urandom % 256);
            nl = VT + ((f == 2) ? 2 : 0);
            for (int l = 0; l < nl; l++) begin
                int len;
                len = HT + ((f % 2 == 1) ? int'($urandom % 3) : 0);
                for (int c = 0; c < len; c++) begin
                    int d;
                    bit vd;
                    if ($urandom % 4 == 0) send(0, 0, 0, 0);
                    if ((c >= HD && c < HD + HF) || c >= ROB0) d = ob_lvl + int'($urandom % 16);
                    else if ($urandom % 4 == 0) d = int'($urandom % ob_lvl);
                    else d = int'($urandom % 1024);
                    vd = (c == 0 && l == 0) || (f == 3 && l == 5 && c == 4);
                    send(c == 0, vd, 1, d);
                end
            end
        end
        send(0, 0, 0, 0);
        send(0, 0, 0, 0);
        done = 1;
        summary();
        $finish;
    end
endmodule